// File: doc/BRIEF.md
# Register File with Banked Stack Pointer

This block is the architectural register store of a 16/32-bit CISC core. It holds eight 32-bit data registers and eight address registers. Address register 7 is not a single register. It is steered to one of two physical stack pointers, one for user mode and one for supervisor mode. The choice follows the supervisor bit of a 16-bit status register, which the block also holds.

Two combinational read ports and one clocked write port each take a 3-bit register index, a data/address select and an operand size. A write narrower than 32 bits merges into the bits it does not touch. A read returns its value zero-extended to the requested size.

The status register can be changed in three ways: a full 16-bit write, a 3-bit interrupt-mask write, or per-flag set and clear strobes. Instruction decode, flag computation and exception sequencing sit outside the block.

Top module: `rf_banked_sp`

## Requirements
- R1: After reset, `sr_o` reads 0x2700 (supervisor bit 13 set, mask 7), and every data register and both stack pointers read zero.
- R2: A long write to an index is returned by a later long read of the same index. A data register and an address register with the same index are separate storage.
- R3: Address index 7 reads and writes the supervisor stack pointer while `sr_o[13]` is 1, and the user stack pointer while it is 0. The two pointers hold independent values.
- R4: Size code 0 (byte) writes bits 7:0 only, and code 1 (word) writes bits 15:0 only. Codes 2 and 3 (long) write all 32 bits. Unwritten bits keep their old value.
- R5: A read with size code 0 returns bits 7:0 with zeros above. Code 1 returns bits 15:0 with zeros above. Codes 2 and 3 return all 32 bits.
- R6: A read of the register being written in the same cycle returns the old value. The new value appears from the next cycle.
- R7: A full status write replaces all 16 bits on the next edge. It takes priority over a mask write and over flag strobes in the same cycle.
- R8: Flag strobe bit i (0 to 6) targets status bit 0, 1, 2, 3, 4, 13 or 15 respectively (carry, overflow, zero, negative, extend, supervisor, trace). A set strobe forces that bit to 1 and a clear strobe forces it to 0. When both are raised for the same bit, clear wins. No other bit changes.
- R9: A mask write places the 3-bit value in status bits 10:8 and leaves every other bit as it was.
- R10: A change of the supervisor bit steers index 7 from the cycle after the status update. In the cycle of the update itself, index 7 still uses the old bit.
- R11: With no status write, mask write or flag strobe, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd0_is_addr_i | input | 1 | Read port 0 selects an address register (1) or a data register (0) |
| rd0_idx_i | input | 3 | Read port 0 register index |
| rd0_size_i | input | 2 | Read port 0 size code |
| rd0_data_o | output | 32 | Read port 0 data, zero-extended |
| rd1_is_addr_i | input | 1 | Read port 1 selects an address register (1) or a data register (0) |
| rd1_idx_i | input | 3 | Read port 1 register index |
| rd1_size_i | input | 2 | Read port 1 size code |
| rd1_data_o | output | 32 | Read port 1 data, zero-extended |
| wr_en_i | input | 1 | Register write enable |
| wr_is_addr_i | input | 1 | Write selects an address register (1) or a data register (0) |
| wr_idx_i | input | 3 | Write register index |
| wr_size_i | input | 2 | Write size code |
| wr_data_i | input | 32 | Write data, low-aligned |
| sr_wr_en_i | input | 1 | Full status write enable |
| sr_wr_data_i | input | 16 | Full status write value |
| mask_wr_en_i | input | 1 | Interrupt-mask write enable |
| mask_wr_data_i | input | 3 | Interrupt-mask value |
| flag_set_i | input | 7 | Per-flag set strobes |
| flag_clr_i | input | 7 | Per-flag clear strobes |
| sr_o | output | 16 | Current status register |

## Verification
The bench targets the banked pointer with care. It switches the supervisor bit both ways, through a full status write and through a flag strobe, and checks index 7 in the update cycle and in the cycle after it. A design that reads the next-state bit would return the other pointer a cycle early, and a design that shares one pointer would return the wrong stack value after the switch.

Narrow writes into a register that already holds a known long value expose a design that clears the upper bits instead of merging them. Byte and word reads of that same register catch a design that returns stale upper bits instead of zeros.

The status tests cover the three ways of changing the register. They raise set and clear together on one flag, combine a full write with other strobes in the same cycle, and write the mask while unrelated bits are 1. A wrong priority, or a mask write that disturbs its neighbours, shows up as a wrong value on `sr_o`.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int XLEN   = 32;
  localparam int SR_W   = 16;
  localparam int IDX_W  = 3;
  localparam int NDATA  = 2 ** IDX_W;
  localparam int NADDR  = NDATA - 1;             // always-physical address regs
  localparam int NPHYS  = NDATA + NADDR + 2;     // + user and supervisor stack
  localparam int PHYS_W = $clog2(NPHYS);
  localparam int NFLAG  = 7;
  localparam int SUPER_BIT = 13;
  localparam int MASK_LO   = 8;
  localparam int MASK_W    = 3;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;
  localparam int unsigned FLAG_POS [NFLAG] = '{0, 1, 2, 3, 4, 13, 15};

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LNG2 = 2'd3
  } op_size_e;

  function automatic logic [XLEN-1:0] size_mask(logic [1:0] sz);
    case (op_size_e'(sz))
      SZ_BYTE: return XLEN'(32'h0000_00ff);
      SZ_WORD: return XLEN'(32'h0000_ffff);
      default: return '1;
    endcase
  endfunction

  // slots: data 0..NDATA-1, address next, then user stack, supervisor stack
  function automatic logic [PHYS_W-1:0] phys_idx(logic is_addr, logic [IDX_W-1:0] idx,
                                                  logic sup);
    if (!is_addr)                      return PHYS_W'(idx);
    else if (idx != IDX_W'(NDATA - 1)) return PHYS_W'(NDATA) + PHYS_W'(idx);
    else if (sup)                      return PHYS_W'(NPHYS - 1);
    else                               return PHYS_W'(NPHYS - 2);
  endfunction
endpackage

// File: rtl/rf_status_reg.sv
module rf_status_reg
  import rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SR_W-1:0]   wr_data_i,
  input  logic              mask_en_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [NFLAG-1:0]  set_i,
  input  logic [NFLAG-1:0]  clr_i,
  output logic [SR_W-1:0]   sr_o,
  output logic              super_o
);
  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (wr_en_i) begin
      sr_d = wr_data_i;
    end else begin
      if (mask_en_i) sr_d[MASK_LO +: MASK_W] = mask_i;
      for (int i = 0; i < NFLAG; i++) begin
        if (set_i[i]) sr_d[FLAG_POS[i]] = 1'b1;
        if (clr_i[i]) sr_d[FLAG_POS[i]] = 1'b0;  // clear wins
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= SR_RESET;
    else         sr_q <= sr_d;
  end

  assign sr_o    = sr_q;
  assign super_o = sr_q[SUPER_BIT];
endmodule

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank
  import rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PHYS_W-1:0] wr_phys_i,
  input  logic [XLEN-1:0]   wr_mask_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic [XLEN-1:0]   regs_o [NPHYS]
);
  logic [XLEN-1:0] regs_q [NPHYS];

  for (genvar g = 0; g < NPHYS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= '0;
      else if (wr_en_i && wr_phys_i == PHYS_W'(g))
        regs_q[g] <= (regs_q[g] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
(
  input  logic [XLEN-1:0]  regs_i [NPHYS],
  input  logic             super_i,
  input  logic             is_addr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       size_i,
  output logic [XLEN-1:0]  data_o
);
  logic [PHYS_W-1:0] phys;

  assign phys   = phys_idx(is_addr_i, idx_i, super_i);
  assign data_o = regs_i[phys] & size_mask(size_i);
endmodule

// File: rtl/rf_banked_sp.sv
module rf_banked_sp
  import rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd0_is_addr_i,
  input  logic [IDX_W-1:0]  rd0_idx_i,
  input  logic [1:0]        rd0_size_i,
  output logic [XLEN-1:0]   rd0_data_o,
  input  logic              rd1_is_addr_i,
  input  logic [IDX_W-1:0]  rd1_idx_i,
  input  logic [1:0]        rd1_size_i,
  output logic [XLEN-1:0]   rd1_data_o,
  input  logic              wr_en_i,
  input  logic              wr_is_addr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [1:0]        wr_size_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              sr_wr_en_i,
  input  logic [SR_W-1:0]   sr_wr_data_i,
  input  logic              mask_wr_en_i,
  input  logic [MASK_W-1:0] mask_wr_data_i,
  input  logic [NFLAG-1:0]  flag_set_i,
  input  logic [NFLAG-1:0]  flag_clr_i,
  output logic [SR_W-1:0]   sr_o
);
  localparam int NRD = 2;

  logic            super_q;
  logic [XLEN-1:0] regs [NPHYS];
  logic            rd_is_addr [NRD];
  logic [IDX_W-1:0] rd_idx    [NRD];
  logic [1:0]      rd_size    [NRD];
  logic [XLEN-1:0] rd_data    [NRD];

  rf_status_reg i_status (
    .clk_i, .rst_ni,
    .wr_en_i   (sr_wr_en_i),
    .wr_data_i (sr_wr_data_i),
    .mask_en_i (mask_wr_en_i),
    .mask_i    (mask_wr_data_i),
    .set_i     (flag_set_i),
    .clr_i     (flag_clr_i),
    .sr_o      (sr_o),
    .super_o   (super_q)
  );

  // write steering uses the registered supervisor bit
  rf_gpr_bank i_bank (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en_i),
    .wr_phys_i (phys_idx(wr_is_addr_i, wr_idx_i, super_q)),
    .wr_mask_i (size_mask(wr_size_i)),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  assign rd_is_addr[0] = rd0_is_addr_i;
  assign rd_idx[0]     = rd0_idx_i;
  assign rd_size[0]    = rd0_size_i;
  assign rd_is_addr[1] = rd1_is_addr_i;
  assign rd_idx[1]     = rd1_idx_i;
  assign rd_size[1]    = rd1_size_i;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_read_port i_port (
      .regs_i    (regs),
      .super_i   (super_q),
      .is_addr_i (rd_is_addr[p]),
      .idx_i     (rd_idx[p]),
      .size_i    (rd_size[p]),
      .data_o    (rd_data[p])
    );
  end

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];
endmodule

// File: rtl/rf_banked_sp_chk.sv
module rf_banked_sp_chk
  import rf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        rd0_size_i,
  input logic [XLEN-1:0]   rd0_data_o,
  input logic [1:0]        rd1_size_i,
  input logic [XLEN-1:0]   rd1_data_o,
  input logic              sr_wr_en_i,
  input logic [SR_W-1:0]   sr_wr_data_i,
  input logic              mask_wr_en_i,
  input logic [MASK_W-1:0] mask_wr_data_i,
  input logic [NFLAG-1:0]  flag_set_i,
  input logic [NFLAG-1:0]  flag_clr_i,
  input logic [SR_W-1:0]   sr_o
);
  p_byte_zext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0_size_i == 2'd0 |-> rd0_data_o[XLEN-1:8] == '0);
  p_word_zext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd1_size_i == 2'd1 |-> rd1_data_o[XLEN-1:16] == '0);
  p_full_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_en_i |=> sr_o == $past(sr_wr_data_i));
  p_carry_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_en_i && flag_set_i[0] && !flag_clr_i[0] |=> sr_o[0]);
  p_trace_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_en_i && flag_clr_i[6] |=> !sr_o[15]);
  p_mask_field_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_en_i && mask_wr_en_i |=> sr_o[MASK_LO +: MASK_W] == $past(mask_wr_data_i));
  p_sr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_en_i && !mask_wr_en_i && flag_set_i == '0 && flag_clr_i == '0 |=> $stable(sr_o));
endmodule

bind rf_banked_sp rf_banked_sp_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd0_size_i     (rd0_size_i),
  .rd0_data_o     (rd0_data_o),
  .rd1_size_i     (rd1_size_i),
  .rd1_data_o     (rd1_data_o),
  .sr_wr_en_i     (sr_wr_en_i),
  .sr_wr_data_i   (sr_wr_data_i),
  .mask_wr_en_i   (mask_wr_en_i),
  .mask_wr_data_i (mask_wr_data_i),
  .flag_set_i     (flag_set_i),
  .flag_clr_i     (flag_clr_i),
  .sr_o           (sr_o)
);

// File: tb/test_rf_banked_sp.sv
module test_rf_banked_sp;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd0_is_addr_i = 0, rd1_is_addr_i = 0;
  logic [2:0]  rd0_idx_i = 0, rd1_idx_i = 0;
  logic [1:0]  rd0_size_i = 2, rd1_size_i = 2;
  logic [31:0] rd0_data_o, rd1_data_o;
  logic        wr_en_i = 0, wr_is_addr_i = 0;
  logic [2:0]  wr_idx_i = 0;
  logic [1:0]  wr_size_i = 2;
  logic [31:0] wr_data_i = 0;
  logic        sr_wr_en_i = 0;
  logic [15:0] sr_wr_data_i = 0;
  logic        mask_wr_en_i = 0;
  logic [2:0]  mask_wr_data_i = 0;
  logic [6:0]  flag_set_i = 0, flag_clr_i = 0;
  logic [15:0] sr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rf_banked_sp i_rf_banked_sp (.clk_i(clk), .*);

  // {we, wa, wi, ws, wd, ra, ri, rs, exp}
  localparam int NV = 10;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 2'd2, 32'h1122_3344, 1'b0, 3'd0, 2'd2, 32'h1122_3344}, // R2
    {1'b1, 1'b1, 3'd0, 2'd2, 32'hAABB_CCDD, 1'b0, 3'd0, 2'd2, 32'h1122_3344}, // R2
    {1'b1, 1'b0, 3'd0, 2'd0, 32'h0000_00EE, 1'b0, 3'd0, 2'd2, 32'h1122_33EE}, // R4
    {1'b1, 1'b0, 3'd0, 2'd1, 32'hFFFF_5566, 1'b0, 3'd0, 2'd2, 32'h1122_5566}, // R4
    {1'b0, 1'b0, 3'd0, 2'd0, 32'h0,         1'b0, 3'd0, 2'd0, 32'h0000_0066}, // R5
    {1'b0, 1'b0, 3'd0, 2'd0, 32'h0,         1'b0, 3'd0, 2'd1, 32'h0000_5566}, // R5
    {1'b1, 1'b1, 3'd7, 2'd2, 32'h0000_1000, 1'b1, 3'd7, 2'd2, 32'h0000_1000}, // R3
    {1'b1, 1'b0, 3'd7, 2'd2, 32'hCAFE_F00D, 1'b1, 3'd0, 2'd1, 32'h0000_CCDD}, // R5
    {1'b1, 1'b1, 3'd6, 2'd1, 32'h0000_1234, 1'b1, 3'd6, 2'd2, 32'h0000_1234}, // R4
    {1'b1, 1'b0, 3'd1, 2'd3, 32'h8765_4321, 1'b0, 3'd1, 2'd2, 32'h8765_4321}  // R4
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd0(logic a, logic [2:0] i, logic [1:0] s);
    rd0_is_addr_i = a; rd0_idx_i = i; rd0_size_i = s;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 sr", 32'(sr_o), 32'h2700);
    rd0(1'b0, 3'd3, 2'd2); chk("R1 d3", rd0_data_o, 0);
    rd0(1'b1, 3'd7, 2'd2); chk("R1 ssp", rd0_data_o, 0);

    for (int k = 0; k < NV; k++) begin
      wr_en_i = VEC[k][76]; wr_is_addr_i = VEC[k][75]; wr_idx_i = VEC[k][74:72];
      wr_size_i = VEC[k][71:70]; wr_data_i = VEC[k][69:38];
      tick();
      wr_en_i = 1'b0;
      rd0(VEC[k][37], VEC[k][36:34], VEC[k][33:32]);
      chk($sformatf("R2/R3/R4/R5 vec%0d", k), rd0_data_o, VEC[k][31:0]);
    end

    // R10: update cycle still uses old bit, next cycle uses new
    sr_wr_en_i = 1'b1; sr_wr_data_i = 16'h0700;
    rd0(1'b1, 3'd7, 2'd2); chk("R10 same cycle ssp", rd0_data_o, 32'h1000);
    tick(); sr_wr_en_i = 1'b0;
    rd0(1'b1, 3'd7, 2'd2); chk("R10 user sp after", rd0_data_o, 0);
    wr_en_i = 1'b1; wr_is_addr_i = 1'b1; wr_idx_i = 3'd7; wr_size_i = 2'd2;
    wr_data_i = 32'h2000;
    tick(); wr_en_i = 1'b0;
    rd0(1'b1, 3'd7, 2'd2); chk("R3 user sp", rd0_data_o, 32'h2000);
    flag_set_i = 7'b010_0000;
    tick(); flag_set_i = '0;
    rd0(1'b1, 3'd7, 2'd2); chk("R3 back to ssp", rd0_data_o, 32'h1000);
    flag_clr_i = 7'b010_0000;
    tick(); flag_clr_i = '0;
    rd0(1'b1, 3'd7, 2'd2); chk("R3 usp kept", rd0_data_o, 32'h2000);
    chk("R8 super cleared", 32'(sr_o), 32'h0700);

    tick(); chk("R11 hold", 32'(sr_o), 32'h0700);
    mask_wr_en_i = 1'b1; mask_wr_data_i = 3'd5;
    tick(); mask_wr_en_i = 1'b0;
    chk("R9 mask 5", 32'(sr_o), 32'h0500);
    flag_set_i = 7'b100_0000;
    tick(); flag_set_i = '0;
    chk("R8 trace set", 32'(sr_o), 32'h8500);
    flag_set_i = 7'b000_0001; flag_clr_i = 7'b000_0001;
    tick(); flag_set_i = '0; flag_clr_i = '0;
    chk("R8 clear wins", 32'(sr_o), 32'h8500);
    flag_set_i = 7'b000_0001;
    tick(); flag_set_i = '0;
    chk("R8 carry set", 32'(sr_o), 32'h8501);

    sr_wr_en_i = 1'b1; sr_wr_data_i = 16'hFFFF;
    flag_clr_i = 7'h7F; mask_wr_en_i = 1'b1; mask_wr_data_i = 3'd0;
    tick(); sr_wr_en_i = 1'b0; flag_clr_i = '0; mask_wr_en_i = 1'b0;
    chk("R7 full write wins", 32'(sr_o), 32'hFFFF);
    mask_wr_en_i = 1'b1; mask_wr_data_i = 3'd2;
    tick(); mask_wr_en_i = 1'b0;
    chk("R9 mask 2 neighbours kept", 32'(sr_o), 32'hFAFF);
    flag_clr_i = 7'b000_1000;
    tick(); flag_clr_i = '0;
    chk("R8 negative clr", 32'(sr_o), 32'hFAF7);

    // R6: read during write sees old value
    wr_en_i = 1'b1; wr_is_addr_i = 1'b0; wr_idx_i = 3'd2; wr_size_i = 2'd2;
    wr_data_i = 32'h5A5A_5A5A;
    rd1_is_addr_i = 1'b0; rd1_idx_i = 3'd2; rd1_size_i = 2'd1;
    rd0(1'b0, 3'd2, 2'd2);
    chk("R6 old rd0", rd0_data_o, 0);
    chk("R6 old rd1", rd1_data_o, 0);
    tick(); wr_en_i = 1'b0; #1;
    chk("R6 new rd0", rd0_data_o, 32'h5A5A_5A5A);
    chk("R6 new rd1 word", rd1_data_o, 32'h0000_5A5A);
    chk("R11 sr kept over reg write", 32'(sr_o), 32'hFAF7);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule